// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This block steps a small microcontroller into and out of its deepest sleep state. The CPU raises a one-cycle halt request. The block then decides what that request should do. If the alternate sleep-variant bit is set, the request has no effect. If the watchdog is running and the watchdog-in-halt option forbids sleeping, the block sends a watchdog reset request and does not sleep. In every other case the block halts. It stops the oscillator, the peripheral clock and the CPU clock, and it strobes a clear of the interrupt mask so that interrupts are enabled.

While halted, only two things can wake the block: the chip reset input, or an interrupt line that is both pending and marked wake-capable. On a wake, the block starts the oscillator at once but keeps the peripheral and CPU clocks off. It holds them off for a fixed settling count. When the count ends it turns both clocks back on and pulses a wake indication. That indication tells the core to fetch the reset vector (after a reset wake) or to service the interrupt (after an interrupt wake).

Top module: `halt_pwr_seq`

## Requirements
- R1: A halt request sampled while `oie_mode` is 1 is ignored: all three clock enables stay 1 and no strobe is produced.
- R2: A halt request with `oie_mode`=0, `wdg_en`=1 and `wdg_halt_rst`=1 produces `wdg_rst_req`=1 for exactly one cycle, in the cycle after the request. All clock enables stay 1 and the block does not halt.
- R3: A halt request that enters halt drives `osc_en`, `periph_clk_en` and `cpu_clk_en` to 0 in the cycle after the request.
- R4: Entering halt produces a one-cycle `imask_clr` pulse in the first halted cycle.
- R5: If a wake-capable interrupt is already pending when halt is entered, the halted state lasts exactly one cycle before the wake sequence starts.
- R6: While halted, only `ext_reset`, or a bit set in both `irq_pend` and `irq_wake_en`, causes a wake. Other interrupts, and further halt requests, have no effect.
- R7: In the cycle after a wake event, `osc_en` is 1 while `periph_clk_en` and `cpu_clk_en` stay 0.
- R8: The settling phase (`osc_en`=1, CPU clock off) lasts exactly SETTLE_CYCLES cycles (default 4096). After it, `periph_clk_en` and `cpu_clk_en` return to 1.
- R9: When the clocks return, `wake_valid` pulses for one cycle. `wake_is_reset` is 1 for a reset wake (reset-vector fetch) and 0 for an interrupt wake (interrupt service).
- R10: If `ext_reset` and a wake-capable interrupt arrive in the same halted cycle, the reset wins and `wake_is_reset` is 1.
- R11: With `wdg_en`=1 and `wdg_halt_rst`=0, a halt request enters halt normally and no watchdog reset is requested.
- R12: The synchronous active-high `rst` sets all three clock enables to 1, `wake_is_reset` to 0 and all strobes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| halt_req | input | 1 | One-cycle halt request from the CPU |
| oie_mode | input | 1 | Sleep-variant status bit; 1 makes the halt request ignored |
| wdg_en | input | 1 | Watchdog is running |
| wdg_halt_rst | input | 1 | Option bit: 1 turns a halt request into a watchdog reset when the watchdog runs |
| ext_reset | input | 1 | Reset wake source |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_wake_en | input | NUM_IRQ | Per-line wake-capable mark |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| imask_clr | output | 1 | One-cycle strobe forcing the interrupt mask to 0 |
| wdg_rst_req | output | 1 | One-cycle watchdog reset request |
| wake_valid | output | 1 | One-cycle pulse when the clocks return after a wake |
| wake_is_reset | output | 1 | 1 = fetch reset vector, 0 = service interrupt |

## Verification
Some properties hold in every cycle, and the assertions check them there. The CPU clock never runs without the oscillator. The watchdog request is a single pulse with the CPU still clocked. The mask-clear strobe only appears with the oscillator off. The wake pulse only appears with both clocks on. The settle counter stays in range. When a reset wake meets an interrupt wake, the recorded source is the reset.

Other behaviours need a scenario to show them, and the bench covers these. One is the exact length of the settling phase. Another is the one-cycle halt when a wake interrupt is already pending. The bench also checks that interrupts without the wake mark, and repeated halt requests while halted, are ignored. Finally, it checks that the sleep-variant bit blocks entry, and that each watchdog option setting leads to the right outcome.

// File: rtl/halt_pwr_pkg.sv
package halt_pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_WDG    = 2'd3
  } hps_state_t;
endpackage

// File: rtl/halt_entry_gate.sv
// Decides what a halt request does while the block is running.
module halt_entry_gate (
  input  logic in_run,
  input  logic halt_req,
  input  logic oie_mode,
  input  logic wdg_en,
  input  logic wdg_halt_rst,
  output logic go_halt,
  output logic go_wdg
);
  logic accepted;
  logic wdg_blocks;

  always_comb begin
    accepted   = in_run && halt_req && !oie_mode;
    wdg_blocks = wdg_en && wdg_halt_rst;
    go_wdg     = accepted && wdg_blocks;
    go_halt    = accepted && !wdg_blocks;
  end
endmodule

// File: rtl/halt_wake_arb.sv
// Selects the wake source; reset outranks any interrupt.
module halt_wake_arb #(
  parameter int NUM_IRQ = 8
) (
  input  logic               ext_reset,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_wake_en,
  output logic               wake_evt,
  output logic               wake_by_reset
);
  logic [NUM_IRQ-1:0] qualified;
  logic               any_irq;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
    assign qualified[i] = irq_pend[i] & irq_wake_en[i];
  end

  always_comb begin
    any_irq = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      any_irq = any_irq | qualified[i];
    end
    wake_by_reset = ext_reset;
    wake_evt      = ext_reset | any_irq;
  end
endmodule

// File: rtl/halt_settle_counter.sv
// Counts oscillator settling cycles; clears whenever not enabled.
module halt_settle_counter #(
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run_en && (cnt_q == LAST);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> cnt_q == '0);
endmodule

// File: rtl/halt_pwr_seq.sv
module halt_pwr_seq
  import halt_pwr_pkg::*;
#(
  parameter int NUM_IRQ       = 8,
  parameter int SETTLE_CYCLES = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_req,
  input  logic               oie_mode,
  input  logic               wdg_en,
  input  logic               wdg_halt_rst,
  input  logic               ext_reset,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_wake_en,
  output logic               osc_en,
  output logic               periph_clk_en,
  output logic               cpu_clk_en,
  output logic               imask_clr,
  output logic               wdg_rst_req,
  output logic               wake_valid,
  output logic               wake_is_reset
);
  hps_state_t state_q, state_d;
  logic go_halt, go_wdg;
  logic wake_evt, wake_by_reset;
  logic settle_done;

  halt_entry_gate u_gate (
    .in_run       (state_q == ST_RUN),
    .halt_req     (halt_req),
    .oie_mode     (oie_mode),
    .wdg_en       (wdg_en),
    .wdg_halt_rst (wdg_halt_rst),
    .go_halt      (go_halt),
    .go_wdg       (go_wdg)
  );

  halt_wake_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .ext_reset     (ext_reset),
    .irq_pend      (irq_pend),
    .irq_wake_en   (irq_wake_en),
    .wake_evt      (wake_evt),
    .wake_by_reset (wake_by_reset)
  );

  halt_settle_counter #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run_en (state_q == ST_SETTLE),
    .done   (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (go_wdg)       state_d = ST_WDG;
        else if (go_halt) state_d = ST_HALT;
      end
      ST_HALT:   if (wake_evt) state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      ST_WDG:    state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_RUN;
      osc_en        <= 1'b1;
      periph_clk_en <= 1'b1;
      cpu_clk_en    <= 1'b1;
      imask_clr     <= 1'b0;
      wdg_rst_req   <= 1'b0;
      wake_valid    <= 1'b0;
      wake_is_reset <= 1'b0;
    end else begin
      state_q       <= state_d;
      osc_en        <= (state_d != ST_HALT);
      periph_clk_en <= (state_d == ST_RUN) || (state_d == ST_WDG);
      cpu_clk_en    <= (state_d == ST_RUN) || (state_d == ST_WDG);
      imask_clr     <= (state_q == ST_RUN) && (state_d == ST_HALT);
      wdg_rst_req   <= (state_d == ST_WDG);
      wake_valid    <= (state_q == ST_SETTLE) && (state_d == ST_RUN);
      if ((state_q == ST_HALT) && wake_evt) begin
        wake_is_reset <= wake_by_reset;
      end
    end
  end

  // R7: the CPU never runs on a stopped oscillator
  p_cpu_needs_osc_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> osc_en);

  p_wdg_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_req |=> !wdg_rst_req);

  p_wdg_no_halt_r2: assert property (@(posedge clk) disable iff (rst)
    wdg_rst_req |-> (cpu_clk_en && osc_en));

  p_imask_in_halt_r4: assert property (@(posedge clk) disable iff (rst)
    imask_clr |-> (!osc_en && !cpu_clk_en));

  p_imask_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    imask_clr |=> !imask_clr);

  p_wake_clocks_r9: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> (cpu_clk_en && periph_clk_en));

  p_reset_prio_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && ext_reset) |=> (wake_is_reset && osc_en));

  p_oie_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req && oie_mode) |=> (cpu_clk_en && !imask_clr && !wdg_rst_req));
endmodule

// File: tb/halt_pwr_seq_tb.sv
module halt_pwr_seq_tb;
  localparam int N      = 8;
  localparam int SETTLE = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, oie_mode = 0, wdg_en = 0, wdg_halt_rst = 0, ext_reset = 0;
  logic [N-1:0] irq_pend = '0, irq_wake_en = '0;
  logic osc_en, periph_clk_en, cpu_clk_en, imask_clr, wdg_rst_req, wake_valid, wake_is_reset;

  always #2.5 clk = ~clk;

  halt_pwr_seq #(.NUM_IRQ(N), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .oie_mode(oie_mode),
    .wdg_en(wdg_en), .wdg_halt_rst(wdg_halt_rst), .ext_reset(ext_reset),
    .irq_pend(irq_pend), .irq_wake_en(irq_wake_en),
    .osc_en(osc_en), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
    .imask_clr(imask_clr), .wdg_rst_req(wdg_rst_req),
    .wake_valid(wake_valid), .wake_is_reset(wake_is_reset)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: mode 0 run, 1 halted, 2 settling, 3 watchdog pulse
  int mode = 0;
  int left = 0;
  bit e_osc = 1, e_p = 1, e_c = 1, e_im = 0, e_wdg = 0, e_wv = 0, e_wir = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mode = 0; left = 0;
      e_osc = 1; e_p = 1; e_c = 1; e_im = 0; e_wdg = 0; e_wv = 0; e_wir = 0;
    end else begin
      e_im = 0; e_wdg = 0; e_wv = 0;
      case (mode)
        0: if (halt_req && !oie_mode) begin
             if (wdg_en && wdg_halt_rst) begin mode = 3; e_wdg = 1; end
             else begin mode = 1; e_osc = 0; e_p = 0; e_c = 0; e_im = 1; end
           end
        1: if (ext_reset) begin mode = 2; e_wir = 1; e_osc = 1; left = SETTLE; end
           else if ((irq_pend & irq_wake_en) != 0) begin
             mode = 2; e_wir = 0; e_osc = 1; left = SETTLE;
           end
        2: begin
             left--;
             if (left == 0) begin mode = 0; e_p = 1; e_c = 1; e_wv = 1; end
           end
        default: mode = 0;
      endcase
    end
  end

  // Per-cycle comparison plus measured phase lengths from the outputs
  int settle_len = 0;
  int halt_len = 0;
  int last_halt_len = 0;
  bit cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(osc_en == e_osc, "R3/R7 osc_en", osc_en, e_osc);
      chk(periph_clk_en == e_p, "R3/R8 periph_clk_en", periph_clk_en, e_p);
      chk(cpu_clk_en == e_c, "R3/R8 cpu_clk_en", cpu_clk_en, e_c);
      chk(imask_clr == e_im, "R4 imask_clr", imask_clr, e_im);
      chk(wdg_rst_req == e_wdg, "R2 wdg_rst_req", wdg_rst_req, e_wdg);
      chk(wake_valid == e_wv, "R9 wake_valid", wake_valid, e_wv);
      chk(wake_is_reset == e_wir, "R9 wake_is_reset", wake_is_reset, e_wir);
      if (!osc_en) halt_len++;
      else if (halt_len > 0) begin last_halt_len = halt_len; halt_len = 0; end
      if (osc_en && !cpu_clk_en) settle_len++;
      else if (settle_len > 0) begin
        chk(settle_len == SETTLE, "R8 settle length", settle_len, SETTLE);
        settle_len = 0;
      end
    end
  end

  task automatic request(input bit oie, input bit wen, input bit opt);
    @(negedge clk);
    oie_mode = oie; wdg_en = wen; wdg_halt_rst = opt; halt_req = 1;
    @(negedge clk);
    halt_req = 0;
  endtask

  task automatic wait_wake();
    for (int i = 0; i < SETTLE + 20; i++) begin
      @(negedge clk);
      if (wake_valid) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R12 reset state
    chk(osc_en && periph_clk_en && cpu_clk_en, "R12 enables after reset", cpu_clk_en, 1);
    chk(!imask_clr && !wdg_rst_req && !wake_valid && !wake_is_reset, "R12 strobes after reset",
        wake_valid, 0);

    // R1 sleep-variant bit set: request ignored
    request(1, 0, 0);
    repeat (2) @(negedge clk);
    chk(cpu_clk_en == 1 && osc_en == 1, "R1 oie request ignored", cpu_clk_en, 1);

    // R2 watchdog forbids halt
    request(0, 1, 1);
    chk(wdg_rst_req == 1, "R2 wdg pulse", wdg_rst_req, 1);
    @(negedge clk);
    chk(wdg_rst_req == 0 && cpu_clk_en == 1, "R2 back to run", wdg_rst_req, 0);

    // R11 watchdog running but halt allowed; R3 clocks off
    request(0, 1, 0);
    chk(osc_en == 0 && cpu_clk_en == 0 && periph_clk_en == 0, "R11 halt entered", osc_en, 0);
    // R6 non-wake interrupt and repeated request ignored
    @(negedge clk); irq_pend = 8'h10; irq_wake_en = 8'h01;
    repeat (5) @(negedge clk);
    halt_req = 1; @(negedge clk); halt_req = 0;
    repeat (2) @(negedge clk);
    chk(osc_en == 0, "R6 still halted", osc_en, 0);
    // wake by interrupt
    irq_pend = 8'h11;
    @(negedge clk); irq_pend = '0;
    @(negedge clk);
    chk(osc_en == 1 && cpu_clk_en == 0, "R7 osc on, cpu off", osc_en, 1);
    wait_wake();
    chk(wake_valid == 1 && wake_is_reset == 0, "R9 interrupt wake", wake_is_reset, 0);

    // R10 simultaneous reset and interrupt
    request(0, 0, 0);
    repeat (3) @(negedge clk);
    ext_reset = 1; irq_pend = 8'h01;
    @(negedge clk); ext_reset = 0; irq_pend = '0;
    wait_wake();
    chk(wake_valid == 1 && wake_is_reset == 1, "R10 reset wins", wake_is_reset, 1);

    // R5 wake interrupt pending at entry
    irq_pend = 8'h01;
    request(0, 0, 0);
    chk(imask_clr == 1, "R4 mask clear on entry", imask_clr, 1);
    @(negedge clk); irq_pend = '0;
    wait_wake();
    chk(last_halt_len == 1, "R5 one-cycle halt", last_halt_len, 1);
    chk(wake_is_reset == 0, "R9 pending interrupt wake", wake_is_reset, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule